// File: doc/BRIEF.md
# Run-Time Width-Selectable Read FIFO

This block is a single-clock first-in first-out buffer. Producers push 36-bit words. Consumers take data out at a width chosen while the buffer runs: 9, 18 or 36 bits. A stored word is handed out as four, two or one transfers. The lowest-order lane always comes first, and the word leaves storage only when its last piece has been taken. The read side is fall-through: the piece that is waiting is always present on `rd_data`, and raising `rd_en` consumes it at the next clock edge.

The width is chosen through a two-bit select input, which is sampled into a register every cycle. A new code is adopted only when the input and its registered copy agree, so the code has to be held across two edges. A single-cycle blip on the select lines therefore leaves the width unchanged. An accepted change waits until no stored word is part-way drained. Flags count whole words only. A push into a full buffer and a pull from an empty one are both refused, and each is reported by a one-cycle pulse.

Top module: `width_adapt_fifo`

## Requirements
- R1: After reset the buffer is empty, `full` is 0, both error pulses are 0 and the active width code `cur_size` is 2'b10 (36 bits).
- R2: A push (`wr_en` high while `full` is low) stores `wr_data` at a clock edge, and stored words come out in the order they were pushed.
- R3: With width code 2'b10, `rd_data` carries the whole head word and each accepted read removes one word.
- R4: With width code 2'b01, a word is delivered as two transfers: bits [17:0] first, then bits [35:18], each placed in `rd_data[17:0]` with bits [35:18] of `rd_data` zero.
- R5: With width code 2'b00, a word is delivered as four transfers: bits [8:0], then [17:9], then [26:18], then [35:27], each placed in `rd_data[8:0]` with the upper bits zero.
- R6: Width codes are 2'b00 = 9 bits, 2'b01 = 18 bits and 2'b10 = 36 bits. The code 2'b11 is never adopted, and the active width stays as it was.
- R7: A code on `size_sel` is adopted at a clock edge only if the same code was also present at the previous edge. So a code held from one edge onward takes effect at the second edge, and a code present at only one edge is ignored.
- R8: A width change is applied only at an edge where no word is partly drained and no read is accepted. A word that has started draining finishes at its old width.
- R9: `empty` is high only when no stored word remains. It stays low while any piece of the head word has not yet been read.
- R10: A read while `empty` is ignored, and `underflow` is high for exactly the following cycle.
- R11: A push while `full` is dropped without changing the stored words, and `overflow` is high for exactly the following cycle. `full` and `empty` are never high together.
- R12: Read and write positions wrap at the buffer depth, so order is kept after more than DEPTH words have passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push request |
| wr_data | input | 36 | Word to push |
| full | output | 1 | All DEPTH word slots are occupied |
| overflow | output | 1 | One-cycle pulse after a refused push |
| rd_en | input | 1 | Consume the piece now on rd_data |
| rd_data | output | 36 | Current piece of the head word, zero-extended |
| empty | output | 1 | No whole word is stored |
| underflow | output | 1 | One-cycle pulse after a refused read |
| size_sel | input | 2 | Requested read width code |
| cur_size | output | 2 | Width code now in force |

## Verification
On every cycle the assertions check the following: the error pulses follow refused accesses, `full` and `empty` are never both high, the fill level stays within bounds, the reserved code is never in force, `empty` stays low while a word is part-drained, and any width change was confirmed over two edges and fell on an idle word boundary. The lane order, the zero-extension of narrow pieces, the exact edge at which a held code takes effect, the rejection of a one-cycle blip, the deferral of a change requested part-way through a word and the preservation of order across pointer wrap can only be shown by the bench's directed scenarios, which compare the data against values the bench works out for itself.

// File: rtl/wafifo_pkg.sv
package wafifo_pkg;

  localparam int WORD_W = 36;
  localparam int LANES  = 4;
  localparam int LANE_W = WORD_W / LANES;
  localparam int HALF_W = WORD_W / 2;

  typedef logic [1:0] size_code_t;

  localparam size_code_t SZ_LANE = 2'b00;
  localparam size_code_t SZ_HALF = 2'b01;
  localparam size_code_t SZ_WORD = 2'b10;
  localparam size_code_t SZ_RSVD = 2'b11;

  // Legal codes are the three defined widths.
  function automatic logic code_ok(input size_code_t c);
    return c != SZ_RSVD;
  endfunction

  // Index of the final piece of a word for a given width.
  function automatic logic [1:0] last_piece(input size_code_t c);
    case (c)
      SZ_LANE: return 2'd3;
      SZ_HALF: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // Select piece idx of word w for width c, zero-extended to WORD_W.
  function automatic logic [WORD_W-1:0] piece_of(input logic [WORD_W-1:0] w,
                                                 input size_code_t c,
                                                 input logic [1:0] idx);
    logic [WORD_W-1:0] r;
    r = '0;
    case (c)
      SZ_LANE: r[LANE_W-1:0] = w[int'(idx)*LANE_W +: LANE_W];
      SZ_HALF: r[HALF_W-1:0] = w[int'(idx[0])*HALF_W +: HALF_W];
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wafifo_store.sv
module wafifo_store
  import wafifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/wafifo_ptrs.sv
module wafifo_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] CAP  = LW'(DEPTH);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assign full  = (level == CAP);
  assign empty = (level == '0);

endmodule

// File: rtl/wafifo_sizer.sv
module wafifo_sizer
  import wafifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  size_code_t size_sel,
  input  logic       busy,
  output size_code_t sel_q,
  output size_code_t active,
  output logic       take
);

  logic confirmed;

  // The code must equal its registered copy from the previous edge.
  assign confirmed = (size_sel == sel_q) && code_ok(size_sel);
  assign take      = confirmed && !busy && (size_sel != active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= SZ_WORD;
      active <= SZ_WORD;
    end else begin
      sel_q <= size_sel;
      if (take) active <= size_sel;
    end
  end

endmodule

// File: rtl/wafifo_slicer.sv
module wafifo_slicer
  import wafifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  size_code_t        active,
  input  logic              rd_fire,
  input  logic [WORD_W-1:0] head,
  output logic [1:0]        sub_idx,
  output logic              sub_last,
  output logic [WORD_W-1:0] piece
);

  assign sub_last = (sub_idx == last_piece(active));
  assign piece    = piece_of(head, active, sub_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_idx <= '0;
    end else if (rd_fire) begin
      sub_idx <= sub_last ? 2'd0 : sub_idx + 2'd1;
    end
  end

endmodule

// File: rtl/width_adapt_fifo.sv
module width_adapt_fifo
  import wafifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [35:0] wr_data,
  output logic        full,
  output logic        overflow,
  input  logic        rd_en,
  output logic [35:0] rd_data,
  output logic        empty,
  output logic        underflow,
  input  logic [1:0]  size_sel,
  output logic [1:0]  cur_size
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic              push;
  logic              rd_fire;
  logic              word_pop;
  logic              busy;
  logic              take;
  logic              sub_last;
  logic [1:0]        sub_idx;
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     rptr;
  logic [LW-1:0]     level;
  logic [WORD_W-1:0] head;
  size_code_t        sel_q;
  size_code_t        active;

  assign push     = wr_en && !full;
  assign rd_fire  = rd_en && !empty;
  assign word_pop = rd_fire && sub_last;
  assign busy     = (sub_idx != 2'd0) || rd_fire;
  assign cur_size = active;

  wafifo_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (head)
  );

  wafifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (word_pop),
    .wptr  (wptr),
    .rptr  (rptr),
    .level (level),
    .full  (full),
    .empty (empty)
  );

  wafifo_sizer u_sizer (
    .clk      (clk),
    .rst_n    (rst_n),
    .size_sel (size_sel),
    .busy     (busy),
    .sel_q    (sel_q),
    .active   (active),
    .take     (take)
  );

  wafifo_slicer u_slicer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .rd_fire  (rd_fire),
    .head     (head),
    .sub_idx  (sub_idx),
    .sub_last (sub_last),
    .piece    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= wr_en && full;
      underflow <= rd_en && empty;
    end
  end

endmodule

// File: rtl/wafifo_chk.sv
module wafifo_chk #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          underflow,
  input logic [1:0]    size_sel,
  input logic [1:0]    cur_size,
  input logic [1:0]    sel_q,
  input logic [1:0]    sub_idx,
  input logic          rd_fire,
  input logic [LW-1:0] level
);

  a_r11_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  a_r11_no_spurious_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full) |=> !overflow);

  a_r10_underflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> underflow);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r6_no_reserved_width: assert property (@(posedge clk) disable iff (!rst_n)
    cur_size != 2'b11);

  a_r9_not_empty_mid_word: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_idx != 2'd0) |-> !empty);

  a_r7_change_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_size) |-> ($past(size_sel) == cur_size) && ($past(sel_q) == cur_size));

  a_r8_change_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_size) |-> ($past(sub_idx) == 2'd0) && !$past(rd_fire));

endmodule

bind width_adapt_fifo wafifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .full      (full),
  .empty     (empty),
  .overflow  (overflow),
  .underflow (underflow),
  .size_sel  (size_sel),
  .cur_size  (cur_size),
  .sel_q     (sel_q),
  .sub_idx   (sub_idx),
  .rd_fire   (rd_fire),
  .level     (level)
);

// File: tb/sim_width_adapt_fifo.sv
module sim_width_adapt_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [35:0] wr_data;
  logic        full;
  logic        overflow;
  logic        rd_en;
  logic [35:0] rd_data;
  logic        empty;
  logic        underflow;
  logic [1:0]  size_sel;
  logic [1:0]  cur_size;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  width_adapt_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .overflow(overflow),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .underflow(underflow),
    .size_sel(size_sel), .cur_size(cur_size)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change after a falling edge; one rising edge follows.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [35:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
    wr_en = 1'b0;
  endtask

  // Check the waiting piece, then consume it.
  task automatic pull(input string req, input logic [35:0] exp);
    check(req, rd_data, exp);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic set_size(input logic [1:0] c);
    size_sel = c;
    tick();
    tick();
  endtask

  task automatic t_reset();
    check("R1 empty", 36'(empty), 36'd1);
    check("R1 full", 36'(full), 36'd0);
    check("R1 width", 36'(cur_size), 36'h2);
    check("R1 pulses", 36'({overflow, underflow}), 36'd0);
  endtask

  task automatic t_wide();
    push(36'h1_2345_6789);
    push(36'hA_BCDE_F012);
    push(36'h5_A5A5_A5A5);
    check("R2 not empty", 36'(empty), 36'd0);
    pull("R3 word0", 36'h1_2345_6789);
    pull("R3 word1", 36'hA_BCDE_F012);
    pull("R2 word2", 36'h5_A5A5_A5A5);
    check("R3 empty after", 36'(empty), 36'd1);
  endtask

  task automatic t_half();
    logic [35:0] w;
    w = 36'hF_0123_4567;
    set_size(2'b01);
    check("R6 half code", 36'(cur_size), 36'h1);
    push(w);
    pull("R4 low half", {18'd0, w[17:0]});
    check("R9 mid-word not empty", 36'(empty), 36'd0);
    pull("R4 high half", {18'd0, w[35:18]});
    check("R9 empty after last half", 36'(empty), 36'd1);
  endtask

  task automatic t_lanes();
    logic [35:0] w;
    w = 36'h9_8765_4321;
    set_size(2'b00);
    check("R6 lane code", 36'(cur_size), 36'h0);
    push(w);
    for (int k = 0; k < 4; k++) begin
      pull("R5 lane", {27'd0, w[k*9 +: 9]});
      if (k < 3) check("R9 partial word", 36'(empty), 36'd0);
    end
    check("R9 empty after lanes", 36'(empty), 36'd1);
  endtask

  task automatic t_select();
    // One-edge blip is rejected.
    size_sel = 2'b01;
    tick();
    size_sel = 2'b00;
    tick();
    tick();
    check("R7 blip ignored", 36'(cur_size), 36'h0);
    // Reserved code never adopted.
    size_sel = 2'b11;
    tick(); tick(); tick();
    check("R6 reserved ignored", 36'(cur_size), 36'h0);
    size_sel = 2'b00;
    tick();
    // Held code takes effect at the second edge.
    size_sel = 2'b10;
    tick();
    check("R7 not yet after one edge", 36'(cur_size), 36'h0);
    tick();
    check("R7 taken at second edge", 36'(cur_size), 36'h2);
  endtask

  task automatic t_defer();
    logic [35:0] w;
    w = 36'h3_C3C3_1E1E;
    set_size(2'b00);
    push(w);
    pull("R8 lane0 old width", {27'd0, w[8:0]});
    size_sel = 2'b10;
    tick(); tick(); tick();
    check("R8 held mid-word", 36'(cur_size), 36'h0);
    for (int k = 1; k < 4; k++) pull("R8 lane old width", {27'd0, w[k*9 +: 9]});
    check("R8 still old on last edge", 36'(cur_size), 36'h0);
    tick();
    check("R8 applied at boundary", 36'(cur_size), 36'h2);
  endtask

  task automatic t_underflow();
    check("R10 starts empty", 36'(empty), 36'd1);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    check("R10 pulse", 36'(underflow), 36'd1);
    check("R10 still empty", 36'(empty), 36'd1);
    tick();
    check("R10 pulse one cycle", 36'(underflow), 36'd0);
  endtask

  task automatic t_overflow();
    // Move pointers off zero so the fill below wraps.
    for (int i = 0; i < 5; i++) push(36'(i) + 36'h100);
    for (int i = 0; i < 5; i++) pull("R12 pre-advance", 36'(i) + 36'h100);
    for (int i = 0; i < DEPTH; i++) push(36'h8_0000_0000 | 36'(i * 7));
    check("R11 full", 36'(full), 36'd1);
    check("R11 overflow quiet", 36'(overflow), 36'd0);
    push(36'hD_EAD0_BEEF);
    check("R11 overflow pulse", 36'(overflow), 36'd1);
    tick();
    check("R11 pulse one cycle", 36'(overflow), 36'd0);
    for (int i = 0; i < DEPTH; i++) pull("R12 order across wrap", 36'h8_0000_0000 | 36'(i * 7));
    check("R11 dropped word absent", 36'(empty), 36'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; size_sel = 2'b10;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_wide();
    t_half();
    t_lanes();
    t_select();
    t_defer();
    t_underflow();
    t_overflow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule